// File: doc/BRIEF.md
# Vector Lane Compare-to-Bitmap Unit

This unit takes two wide vectors and splits each one into lanes of signed integers. It compares each pair of lanes under a selectable relation and packs the per-lane outcomes into a bitmap, with one bit for each lane. The bitmap can be gated by a caller-supplied lane mask. It can then be combined with a second bitmap by a small bitwise logic stage. The unit also reports how many bits of the final bitmap are set. Software-style vector code uses such bitmaps to select lanes for later masked operations, or to count matching elements.

A transaction is presented for one cycle with `in_valid` high. The bitmap, its population count and `out_valid` appear on the next rising edge. The outputs then hold until the next accepted transaction. Reset is asynchronous and active-low. Internally it is released through a two-stage synchroniser, so the unit begins accepting work two cycles after `rst_n` rises.

Top module: `simd_cmp_mask`

## Requirements
- R1: Lane i occupies bits [i*LANE_W + LANE_W-1 : i*LANE_W] of each vector. Lanes are compared as two's-complement signed values, and the result for lane i appears at bit i of `mask_out`.
- R2: `cmp_op` selects the relation `a OP b`: 0 equal, 1 less-than, 2 less-or-equal, 3 greater-than, 4 greater-or-equal, 5 not-equal.
- R3: A `cmp_op` of 6 or 7 yields an all-zero compare bitmap.
- R4: When `mask_en` is 1, the compare bitmap is ANDed with `mask_in`. When `mask_en` is 0, `mask_in` has no effect on any output.
- R5: `klog_op` combines the gated compare bitmap G with `klog_b` as follows: 0 G, 1 G&B, 2 ~(G&B), 3 ~G, 4 G|B, 5 ~(G^B), 6 G^B, 7 all zero.
- R6: `pop_out` always equals the number of ones in `mask_out`.
- R7: An input accepted at a rising edge (`in_valid`=1) shows on `mask_out`/`pop_out` right after that edge. `out_valid` is 1 for exactly those cycles that follow an accepted input.
- R8: While `in_valid` is 0, `mask_out` and `pop_out` keep their values, whatever the other inputs do.
- R9: While reset is applied, `out_valid`, `mask_out` and `pop_out` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Transaction strobe |
| vec_a | input | LANES*LANE_W | Left-hand vector |
| vec_b | input | LANES*LANE_W | Right-hand vector |
| cmp_op | input | 3 | Compare relation code |
| mask_en | input | 1 | Apply `mask_in` when 1 |
| mask_in | input | LANES | Lane gating mask |
| klog_op | input | 3 | Bitmap logic operation code |
| klog_b | input | LANES | Second bitmap operand |
| out_valid | output | 1 | Result strobe |
| mask_out | output | LANES | Final lane bitmap |
| pop_out | output | clog2(LANES+1) | Count of set bits in `mask_out` |

## Verification
The bench builds the unit with its default shape of sixteen lanes of 32 bits. This means a bitmap of all ones gives the widest count, 16, and that count exercises the top bit of the 5-bit `pop_out`. With 32-bit lanes the bench can place the most negative and most positive values side by side. That pairing separates a signed comparison from an unsigned one. It also places lane boundaries where a slicing error shows up as a wrong bit.

// File: rtl/simd_cmp_pkg.sv
package simd_cmp_pkg;

  typedef enum logic [2:0] {
    CMP_EQ   = 3'd0,
    CMP_LT   = 3'd1,
    CMP_LE   = 3'd2,
    CMP_GT   = 3'd3,
    CMP_GE   = 3'd4,
    CMP_NE   = 3'd5,
    CMP_RSV6 = 3'd6,
    CMP_RSV7 = 3'd7
  } cmp_op_e;

  typedef enum logic [2:0] {
    KL_PASS = 3'd0,
    KL_AND  = 3'd1,
    KL_NAND = 3'd2,
    KL_NOT  = 3'd3,
    KL_OR   = 3'd4,
    KL_XNOR = 3'd5,
    KL_XOR  = 3'd6,
    KL_ZERO = 3'd7
  } klog_op_e;

endpackage

// File: rtl/simd_lane_cmp.sv
module simd_lane_cmp
  import simd_cmp_pkg::*;
#(
  parameter int unsigned LANE_W = 32
) (
  input  logic [LANE_W-1:0] lane_a,
  input  logic [LANE_W-1:0] lane_b,
  input  cmp_op_e           op,
  output logic              hit
);

  logic is_eq;
  logic is_lt;

  // Signed relations from one equality and one less-than
  always_comb begin
    is_eq = (lane_a == lane_b);
    is_lt = ($signed(lane_a) < $signed(lane_b));
  end

  always_comb begin
    case (op)
      CMP_EQ:  hit = is_eq;
      CMP_LT:  hit = is_lt;
      CMP_LE:  hit = is_lt | is_eq;
      CMP_GT:  hit = ~(is_lt | is_eq);
      CMP_GE:  hit = ~is_lt;
      CMP_NE:  hit = ~is_eq;
      default: hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/simd_mask_logic.sv
module simd_mask_logic
  import simd_cmp_pkg::*;
#(
  parameter int unsigned N = 16
) (
  input  logic [N-1:0] opnd_g,
  input  logic [N-1:0] opnd_b,
  input  klog_op_e     op,
  output logic [N-1:0] res
);

  always_comb begin
    case (op)
      KL_PASS: res = opnd_g;
      KL_AND:  res = opnd_g & opnd_b;
      KL_NAND: res = ~(opnd_g & opnd_b);
      KL_NOT:  res = ~opnd_g;
      KL_OR:   res = opnd_g | opnd_b;
      KL_XNOR: res = ~(opnd_g ^ opnd_b);
      KL_XOR:  res = opnd_g ^ opnd_b;
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/simd_popcount.sv
module simd_popcount #(
  parameter int unsigned N  = 16,
  localparam int unsigned CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  bits,
  output logic [CW-1:0] count
);

  always_comb begin
    count = '0;
    for (int i = 0; i < int'(N); i++) begin
      count = count + CW'(bits[i]);
    end
  end

endmodule

// File: rtl/simd_cmp_mask.sv
module simd_cmp_mask
  import simd_cmp_pkg::*;
#(
  parameter int unsigned LANES  = 16,
  parameter int unsigned LANE_W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [LANES*LANE_W-1:0]     vec_a,
  input  logic [LANES*LANE_W-1:0]     vec_b,
  input  logic [2:0]                  cmp_op,
  input  logic                        mask_en,
  input  logic [LANES-1:0]            mask_in,
  input  logic [2:0]                  klog_op,
  input  logic [LANES-1:0]            klog_b,
  output logic                        out_valid,
  output logic [LANES-1:0]            mask_out,
  output logic [$clog2(LANES+1)-1:0]  pop_out
);

  localparam int unsigned POP_W = $clog2(LANES + 1);

  // Reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // Per-lane compare
  cmp_op_e          cmp_sel;
  logic [LANES-1:0] raw_hits;

  assign cmp_sel = cmp_op_e'(cmp_op);

  for (genvar g = 0; g < int'(LANES); g++) begin : g_lane
    simd_lane_cmp #(
      .LANE_W (LANE_W)
    ) u_lane (
      .lane_a (vec_a[g*LANE_W +: LANE_W]),
      .lane_b (vec_b[g*LANE_W +: LANE_W]),
      .op     (cmp_sel),
      .hit    (raw_hits[g])
    );
  end

  // Lane gating
  logic [LANES-1:0] gate_mask;
  logic [LANES-1:0] gated_hits;

  always_comb begin
    gate_mask  = mask_en ? mask_in : '1;
    gated_hits = raw_hits & gate_mask;
  end

  // Bitmap logic and count
  logic [LANES-1:0] final_mask;
  logic [POP_W-1:0] final_pop;

  simd_mask_logic #(
    .N (LANES)
  ) u_klog (
    .opnd_g (gated_hits),
    .opnd_b (klog_b),
    .op     (klog_op_e'(klog_op)),
    .res    (final_mask)
  );

  simd_popcount #(
    .N (LANES)
  ) u_pop (
    .bits  (final_mask),
    .count (final_pop)
  );

  // Next state
  logic             load_en;
  logic             vld_d;
  logic [LANES-1:0] mask_d;
  logic [POP_W-1:0] pop_d;

  always_comb begin
    load_en = in_valid;
    vld_d   = in_valid;
    mask_d  = mask_out;
    pop_d   = pop_out;
    if (load_en) begin
      mask_d = final_mask;
      pop_d  = final_pop;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      mask_out  <= '0;
      pop_out   <= '0;
    end else if (!rst_sync_n) begin
      out_valid <= 1'b0;
      mask_out  <= '0;
      pop_out   <= '0;
    end else begin
      out_valid <= vld_d;
      mask_out  <= mask_d;
      pop_out   <= pop_d;
    end
  end

endmodule

// File: rtl/simd_cmp_mask_chk.sv
module simd_cmp_mask_chk #(
  parameter int unsigned LANES = 16
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        rst_sync_n,
  input logic                        in_valid,
  input logic [2:0]                  cmp_op,
  input logic                        mask_en,
  input logic [LANES-1:0]            mask_in,
  input logic [2:0]                  klog_op,
  input logic                        out_valid,
  input logic [LANES-1:0]            mask_out,
  input logic [$clog2(LANES+1)-1:0]  pop_out
);

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && mask_out == '0 && pop_out == '0));

  // R6
  pop_match_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pop_out == $countones(mask_out));

  // R7
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid == $past(in_valid && rst_sync_n));

  // R8
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!in_valid && rst_sync_n) |=> ($stable(mask_out) && $stable(pop_out)));

  // R4
  gate_apply_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && mask_en && klog_op == 3'd0) |=> ((mask_out & ~$past(mask_in)) == '0));

  // R3
  bad_op_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && cmp_op > 3'd5 && klog_op == 3'd0) |=> (mask_out == '0));

endmodule

bind simd_cmp_mask simd_cmp_mask_chk #(
  .LANES (LANES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_sync_n (rst_sync_n),
  .in_valid   (in_valid),
  .cmp_op     (cmp_op),
  .mask_en    (mask_en),
  .mask_in    (mask_in),
  .klog_op    (klog_op),
  .out_valid  (out_valid),
  .mask_out   (mask_out),
  .pop_out    (pop_out)
);

// File: tb/test_simd_cmp_mask.sv
module test_simd_cmp_mask;

  localparam int L = 16;
  localparam int W = 32;
  localparam int PW = $clog2(L + 1);

  logic              clk;
  logic              rst_n;
  logic              in_valid;
  logic [L*W-1:0]    vec_a;
  logic [L*W-1:0]    vec_b;
  logic [2:0]        cmp_op;
  logic              mask_en;
  logic [L-1:0]      mask_in;
  logic [2:0]        klog_op;
  logic [L-1:0]      klog_b;
  logic              out_valid;
  logic [L-1:0]      mask_out;
  logic [PW-1:0]     pop_out;

  int checks;
  int failures;
  bit done;

  simd_cmp_mask #(.LANES(L), .LANE_W(W)) i_simd_cmp_mask (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .vec_a(vec_a), .vec_b(vec_b), .cmp_op(cmp_op),
    .mask_en(mask_en), .mask_in(mask_in),
    .klog_op(klog_op), .klog_b(klog_b),
    .out_valid(out_valid), .mask_out(mask_out), .pop_out(pop_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [L-1:0] ref_cmp(input logic [L*W-1:0] a, input logic [L*W-1:0] b, input logic [2:0] op);
    logic [L-1:0] r;
    for (int i = 0; i < L; i++) begin
      logic signed [W-1:0] x;
      logic signed [W-1:0] y;
      x = a[i*W +: W];
      y = b[i*W +: W];
      case (op)
        3'd0: r[i] = (x == y);
        3'd1: r[i] = (x < y);
        3'd2: r[i] = (x <= y);
        3'd3: r[i] = (x > y);
        3'd4: r[i] = (x >= y);
        3'd5: r[i] = (x != y);
        default: r[i] = 1'b0;
      endcase
    end
    return r;
  endfunction

  function automatic logic [L-1:0] ref_klog(input logic [L-1:0] g, input logic [L-1:0] b, input logic [2:0] op);
    case (op)
      3'd0: return g;
      3'd1: return g & b;
      3'd2: return ~(g & b);
      3'd3: return ~g;
      3'd4: return g | b;
      3'd5: return ~(g ^ b);
      3'd6: return g ^ b;
      default: return '0;
    endcase
  endfunction

  function automatic int ones(input logic [L-1:0] m);
    int n = 0;
    for (int i = 0; i < L; i++) n += int'(m[i]);
    return n;
  endfunction

  // Drive one transaction at a falling edge, sample after the next rising edge
  task automatic run_op(input logic [L*W-1:0] a, input logic [L*W-1:0] b, input logic [2:0] op,
                        input logic men, input logic [L-1:0] mi, input logic [2:0] kop,
                        input logic [L-1:0] kb, input string req);
    logic [L-1:0] g;
    logic [L-1:0] e;
    @(negedge clk);
    in_valid = 1'b1; vec_a = a; vec_b = b; cmp_op = op;
    mask_en = men; mask_in = mi; klog_op = kop; klog_b = kb;
    @(negedge clk);
    in_valid = 1'b0;
    g = ref_cmp(a, b, op) & (men ? mi : '1);
    e = ref_klog(g, kb, kop);
    chk(mask_out == e, req, 32'(mask_out), 32'(e));
    chk(int'(pop_out) == ones(e), "R6", 32'(pop_out), 32'(ones(e)));
    chk(out_valid == 1'b1, "R7", 32'(out_valid), 32'd1);
  endtask

  function automatic logic [L*W-1:0] mk_vec(input int seed);
    logic [L*W-1:0] v;
    for (int i = 0; i < L; i++) v[i*W +: W] = 32'(seed * 7 + (i % 3) - 1);
    return v;
  endfunction

  task automatic t_reset;
    // R9
    chk(out_valid == 1'b0, "R9", 32'(out_valid), 32'd0);
    chk(mask_out == '0, "R9", 32'(mask_out), 32'd0);
    chk(pop_out == '0, "R9", 32'(pop_out), 32'd0);
  endtask

  task automatic t_relations;
    logic [L*W-1:0] a;
    logic [L*W-1:0] b;
    // R1 R2: mixed sign extremes and equals across lanes
    for (int i = 0; i < L; i++) begin
      case (i % 4)
        0: begin a[i*W +: W] = 32'h8000_0000; b[i*W +: W] = 32'h7FFF_FFFF; end
        1: begin a[i*W +: W] = 32'h7FFF_FFFF; b[i*W +: W] = 32'h8000_0000; end
        2: begin a[i*W +: W] = 32'hFFFF_FFFF; b[i*W +: W] = 32'hFFFF_FFFF; end
        default: begin a[i*W +: W] = 32'd5; b[i*W +: W] = 32'hFFFF_FFFB; end
      endcase
    end
    for (int op = 0; op < 6; op++) run_op(a, b, 3'(op), 1'b0, '0, 3'd0, '0, "R2");
    // R1: a single differing lane lands at its own bit
    run_op('0, {{(L-6)*W{1'b0}}, 32'd1, {5*W{1'b0}}}, 3'd1, 1'b0, '0, 3'd0, '0, "R1");
    run_op(mk_vec(3), mk_vec(4), 3'd4, 1'b0, '0, 3'd0, '0, "R1");
  endtask

  task automatic t_bad_op;
    // R3
    run_op(mk_vec(1), mk_vec(1), 3'd6, 1'b0, '0, 3'd0, '0, "R3");
    run_op(mk_vec(1), mk_vec(2), 3'd7, 1'b0, '0, 3'd0, '0, "R3");
  endtask

  task automatic t_gate;
    // R4: all-equal vectors give all ones before gating
    run_op(mk_vec(2), mk_vec(2), 3'd0, 1'b1, 16'hA5C3, 3'd0, '0, "R4");
    run_op(mk_vec(2), mk_vec(2), 3'd0, 1'b0, 16'h0000, 3'd0, '0, "R4");
    chk(pop_out == PW'(16), "R4", 32'(pop_out), 32'd16);
  endtask

  task automatic t_klog;
    // R5: every logic code over a fixed gated operand
    for (int k = 0; k < 8; k++)
      run_op(mk_vec(2), mk_vec(2), 3'd0, 1'b1, 16'hF0F0, 3'(k), 16'hCC33, "R5");
  endtask

  task automatic t_hold;
    logic [L-1:0] m0;
    logic [PW-1:0] p0;
    // R8 R7
    run_op(mk_vec(5), mk_vec(6), 3'd1, 1'b1, 16'h3C3C, 3'd0, '0, "R8");
    m0 = mask_out; p0 = pop_out;
    vec_a = mk_vec(9); vec_b = mk_vec(0); cmp_op = 3'd5; mask_en = 1'b0;
    klog_op = 3'd3; klog_b = 16'hFFFF;
    repeat (3) @(negedge clk);
    chk(mask_out == m0, "R8", 32'(mask_out), 32'(m0));
    chk(pop_out == p0, "R8", 32'(pop_out), 32'(p0));
    chk(out_valid == 1'b0, "R7", 32'(out_valid), 32'd0);
  endtask

  initial begin
    checks = 0; failures = 0; done = 0;
    rst_n = 1'b0; in_valid = 1'b0; vec_a = '0; vec_b = '0; cmp_op = '0;
    mask_en = 1'b0; mask_in = '0; klog_op = '0; klog_b = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_relations();
    t_bad_op();
    t_gate();
    t_klog();
    t_hold();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule